// File: doc/BRIEF.md
# E-paper Multi-Frame Update Sequencer

This block runs one e-paper panel update, which is made of a programmed number of refresh frames. Software writes a start/count word, an interrupt word and a line number through a small register-write port. None of these values acts until a commit strobe copies the staged copies into the active set. A rising edge of the committed start bit launches the update. The block then counts frame-done pulses from the panel timing generator until the programmed number of frames has passed.

While an update runs, the block raises four interrupt causes: end of each frame, end of the whole update, a software-chosen frame, and a chosen line within a frame. Each cause has a status bit, a mask bit and a write-one-to-clear bit. A single level interrupt line reports any unmasked pending cause.

The controller has two states. ST_IDLE is entered at reset. It moves to ST_RUN on a launch, when a commit brings the start bit from 0 to 1. ST_RUN returns to ST_IDLE on the frame-done pulse of the last frame. The run output is high exactly in ST_RUN.

Top module: `ep_update_seq`

## Requirements
- R1: After reset, run is 0, frame_idx is 0 and irq is 0. All masks reset to 1 (masked) and all status bits reset to 0.
- R2: Writes take effect only on commit. The write selects are wr_sel 0 for the start word, 1 for the interrupt word and 2 for the line number. A write with wr_sel 0, 1 or 2 changes only a staged copy. The staged copies become active when a write with wr_sel 3 carries wr_data[0]=1.
- R3: The start word holds the start bit at bit 0 and the frame count minus one at bits 9:2. A commit that moves the active start bit from 0 to 1 in ST_IDLE enters ST_RUN, with run=1 and frame_idx=0 in the next cycle.
- R4: In ST_RUN, each frame_done pulse increments frame_idx. The pulse that arrives with frame_idx equal to the captured count field returns the block to ST_IDLE with frame_idx=0, so an update lasts field+1 frames (1 to 256). frame_done has no effect in ST_IDLE.
- R5: A launch edge that is committed while in ST_RUN is ignored. run, frame_idx and the captured frame count are left unchanged.
- R6: Status bit 0 (frame end) is set by every frame_done pulse in ST_RUN.
- R7: Status bit 1 (update end) is set by the frame_done pulse of the last frame.
- R8: Status bit 2 (chosen frame) is set by a frame_done pulse in ST_RUN when frame_idx equals interrupt-word bits 19:12.
- R9: Status bit 3 (line flag) is set by a line_pulse in ST_RUN when the count of line pulses already seen in the current frame equals the committed line number. That count restarts at launch and at every frame_done. line_pulse has no effect in ST_IDLE.
- R10: Interrupt-word bits 7:4 are the masks for causes 0..3. irq is the OR over all causes of status AND NOT mask.
- R11: Interrupt-word bits 11:8 clear the matching status bits at the write itself, with no commit needed. A set and a clear of the same bit in the same cycle leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 start, 1 interrupt, 2 line number, 3 commit |
| wr_data | input | 20 | Write data |
| frame_done | input | 1 | One-cycle end-of-frame pulse from the timing generator |
| line_pulse | input | 1 | One-cycle line pulse from the timing generator |
| run | output | 1 | High while an update is in progress |
| frame_idx | output | 8 | Index of the frame currently being driven |
| irq | output | 1 | Level interrupt, any unmasked pending cause |

## Verification
The bench sweeps frame counts from 1 to 256. A design that stored the count without the minus-one offset would end one frame late, and one that failed to reset the index would report a nonzero index once idle. It walks all sixteen mask settings against every remaining status pattern, which exposes a swapped or inverted mask. It relaunches while an update is running, which a design reacting to every commit edge would restart. It also issues a clear in the same cycle as a frame end, which a clear-priority design would lose. Line flags are checked across two frames and while idle, which catches a counter that does not restart per frame or runs outside an update.

// File: rtl/ep_seq_pkg.sv
package ep_seq_pkg;

    localparam int FRM_W    = 8;
    localparam int WORD_W   = 20;
    localparam int NCAUSE   = 4;

    localparam int START_BIT = 0;
    localparam int TOT_LSB   = 2;
    localparam int MASK_LSB  = 4;
    localparam int CLR_LSB   = 8;
    localparam int PICK_LSB  = 12;

    localparam int CAUSE_FEND = 0;
    localparam int CAUSE_DEND = 1;
    localparam int CAUSE_PICK = 2;
    localparam int CAUSE_LINE = 3;

    typedef enum logic [1:0] {
        SEL_START  = 2'd0,
        SEL_IRQ    = 2'd1,
        SEL_LINE   = 2'd2,
        SEL_COMMIT = 2'd3
    } wr_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/ep_cfg_shadow.sv
module ep_cfg_shadow
    import ep_seq_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic              launch_req,
    output logic [FRM_W-1:0]  launch_total,
    output logic [FRM_W-1:0]  act_pick,
    output logic [NCAUSE-1:0] act_mask,
    output logic [LINE_W-1:0] act_line,
    output logic [NCAUSE-1:0] clr_vec
);

    logic              wr_start, wr_irq, wr_line, commit;
    logic              sh_start, act_start;
    logic [FRM_W-1:0]  sh_total, sh_pick;
    logic [NCAUSE-1:0] sh_mask;
    logic [LINE_W-1:0] sh_line;

    assign wr_start = wr_en && (wr_sel == SEL_START);
    assign wr_irq   = wr_en && (wr_sel == SEL_IRQ);
    assign wr_line  = wr_en && (wr_sel == SEL_LINE);
    assign commit   = wr_en && (wr_sel == SEL_COMMIT) && wr_data[0];

    // staged copies
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_start <= 1'b0;
            sh_total <= '0;
            sh_pick  <= '0;
            sh_mask  <= '1;
            sh_line  <= '0;
        end else begin
            if (wr_start) begin
                sh_start <= wr_data[START_BIT];
                sh_total <= wr_data[TOT_LSB +: FRM_W];
            end
            if (wr_irq) begin
                sh_mask <= wr_data[MASK_LSB +: NCAUSE];
                sh_pick <= wr_data[PICK_LSB +: FRM_W];
            end
            if (wr_line)
                sh_line <= wr_data[LINE_W-1:0];
        end
    end

    // active copies, loaded on commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_start <= 1'b0;
            act_pick  <= '0;
            act_mask  <= '1;
            act_line  <= '0;
        end else if (commit) begin
            act_start <= sh_start;
            act_pick  <= sh_pick;
            act_mask  <= sh_mask;
            act_line  <= sh_line;
        end
    end

    assign launch_req   = commit && sh_start && !act_start;
    assign launch_total = sh_total;
    assign clr_vec      = wr_irq ? wr_data[CLR_LSB +: NCAUSE] : '0;

endmodule

// File: rtl/ep_frame_seq.sv
module ep_frame_seq
    import ep_seq_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_req,
    input  logic [FRM_W-1:0]  launch_total,
    input  logic [FRM_W-1:0]  act_pick,
    input  logic [LINE_W-1:0] act_line,
    input  logic              frame_done,
    input  logic              line_pulse,
    output logic              run,
    output logic [FRM_W-1:0]  frame_idx,
    output logic [FRM_W-1:0]  run_total,
    output logic [NCAUSE-1:0] set_vec
);

    seq_state_e        state_q, state_d;
    logic [LINE_W-1:0] line_cnt;
    logic              last_frame;

    assign last_frame = frame_done && (frame_idx == run_total);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch_req) state_d = ST_RUN;
            ST_RUN:  if (last_frame) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_idx <= '0;
            run_total <= '0;
            line_cnt  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (launch_req) begin
                        frame_idx <= '0;
                        run_total <= launch_total;
                        line_cnt  <= '0;
                    end
                end
                ST_RUN: begin
                    if (frame_done) begin
                        line_cnt  <= '0;
                        frame_idx <= last_frame ? '0 : frame_idx + 1'b1;
                    end else if (line_pulse) begin
                        line_cnt <= line_cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign run = (state_q == ST_RUN);

    always_comb begin
        set_vec             = '0;
        set_vec[CAUSE_FEND] = run && frame_done;
        set_vec[CAUSE_DEND] = run && last_frame;
        set_vec[CAUSE_PICK] = run && frame_done && (frame_idx == act_pick);
        set_vec[CAUSE_LINE] = run && line_pulse && (line_cnt == act_line);
    end

endmodule

// File: rtl/ep_irq_status.sv
module ep_irq_status
    import ep_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCAUSE-1:0] set_vec,
    input  logic [NCAUSE-1:0] clr_vec,
    input  logic [NCAUSE-1:0] act_mask,
    output logic [NCAUSE-1:0] stat,
    output logic              irq
);

    for (genvar i = 0; i < NCAUSE; i++) begin : g_cause
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          stat[i] <= 1'b0;
            else if (set_vec[i]) stat[i] <= 1'b1;
            else if (clr_vec[i]) stat[i] <= 1'b0;
        end
    end

    assign irq = |(stat & ~act_mask);

endmodule

// File: rtl/ep_update_seq.sv
module ep_update_seq
    import ep_seq_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              frame_done,
    input  logic              line_pulse,
    output logic              run,
    output logic [FRM_W-1:0]  frame_idx,
    output logic              irq
);

    logic              launch_req;
    logic [FRM_W-1:0]  launch_total, act_pick, run_total;
    logic [NCAUSE-1:0] act_mask, clr_vec, set_vec, stat;
    logic [LINE_W-1:0] act_line;

    ep_cfg_shadow #(.LINE_W(LINE_W)) u_shadow (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .launch_req   (launch_req),
        .launch_total (launch_total),
        .act_pick     (act_pick),
        .act_mask     (act_mask),
        .act_line     (act_line),
        .clr_vec      (clr_vec)
    );

    ep_frame_seq #(.LINE_W(LINE_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch_req   (launch_req),
        .launch_total (launch_total),
        .act_pick     (act_pick),
        .act_line     (act_line),
        .frame_done   (frame_done),
        .line_pulse   (line_pulse),
        .run          (run),
        .frame_idx    (frame_idx),
        .run_total    (run_total),
        .set_vec      (set_vec)
    );

    ep_irq_status u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .act_mask (act_mask),
        .stat     (stat),
        .irq      (irq)
    );

endmodule

// File: rtl/ep_update_seq_chk.sv
module ep_update_seq_chk
    import ep_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              frame_done,
    input logic              launch_req,
    input logic [FRM_W-1:0]  frame_idx,
    input logic [FRM_W-1:0]  run_total,
    input logic [NCAUSE-1:0] stat
);

    AST_IDLE_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> frame_idx == '0); // R4

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> frame_idx <= run_total); // R4

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run && frame_done && (frame_idx != run_total)
        |=> run && (frame_idx == $past(frame_idx) + 1'b1)); // R4

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        run && !frame_done |=> $stable(frame_idx)); // R4

    AST_END_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> stat[CAUSE_DEND] && stat[CAUSE_FEND]); // R7

    AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        run && launch_req && !frame_done |=> run && $stable(run_total)); // R5

endmodule

bind ep_update_seq ep_update_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .frame_done (frame_done),
    .launch_req (launch_req),
    .frame_idx  (frame_idx),
    .run_total  (run_total),
    .stat       (stat)
);

// File: tb/tb_ep_update_seq.sv
module tb_ep_update_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [19:0] wr_data = '0;
    logic        frame_done = 1'b0;
    logic        line_pulse = 1'b0;
    logic        run;
    logic [7:0]  frame_idx;
    logic        irq;

    int nchk = 0;
    int nfail = 0;
    int cur_pick = 0;

    always #5 clk = ~clk;

    ep_update_seq dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .frame_done(frame_done), .line_pulse(line_pulse),
        .run(run), .frame_idx(frame_idx), .irq(irq)
    );

    task automatic chk(input int act, input int exp, input string tag);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [19:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic commit();
        wr(2'd3, 20'd1);
    endtask

    task automatic irqw(input int mask, input int clr, input int pick);
        wr(2'd1, 20'((pick << 12) | (clr << 8) | (mask << 4)));
    endtask

    task automatic setmask(input int mask);
        irqw(mask, 0, cur_pick);
        commit();
    endtask

    task automatic fd();
        @(negedge clk); frame_done = 1'b1;
        @(negedge clk); frame_done = 1'b0;
    endtask

    task automatic lp();
        @(negedge clk); line_pulse = 1'b1;
        @(negedge clk); line_pulse = 1'b0;
    endtask

    task automatic launch(input int n);
        wr(2'd0, 20'((n - 1) << 2));
        commit();
        wr(2'd0, 20'(((n - 1) << 2) | 1));
        commit();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R4 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        int tots[7];
        int remain;
        tots = '{1, 2, 3, 4, 7, 16, 256};

        repeat (3) @(negedge clk);
        chk(run, 0, "R1 run");
        chk(frame_idx, 0, "R1 idx");
        chk(irq, 0, "R1 irq");
        rst_n = 1'b1;
        @(negedge clk);
        chk(run, 0, "R1 run after release");

        // staged start, single-frame update
        wr(2'd0, 20'd1);
        repeat (3) @(negedge clk);
        chk(run, 0, "R2 start without commit");
        commit();
        chk(run, 1, "R3 launch run");
        chk(frame_idx, 0, "R3 launch idx");
        fd();
        chk(run, 0, "R4 one frame done");
        chk(frame_idx, 0, "R4 idx idle");
        irqw(4'hE, 0, 0);
        chk(irq, 0, "R2 mask without commit");
        commit();
        chk(irq, 1, "R10 frame end unmasked");
        irqw(4'hE, 1, 0);
        chk(irq, 0, "R11 immediate clear");
        cur_pick = 0;
        setmask(4'hD);
        chk(irq, 1, "R11 other bit kept");
        irqw(4'hF, 4'hF, 0);
        commit();

        // frame-count sweep
        wr(2'd2, 20'd5);
        commit();
        for (int i = 0; i < 7; i++) begin
            int n;
            int pk;
            int expv;
            n  = tots[i];
            pk = (i % 2 == 0) ? n / 2 : ((n / 2 + 200 > 255) ? 255 : n / 2 + 200);
            cur_pick = pk;
            irqw(4'hF, 4'hF, pk);
            commit();
            launch(n);
            chk(run, 1, "R3 sweep launch");
            chk(frame_idx, 0, "R3 sweep idx");
            for (int f = 0; f < n; f++) begin
                lp();
                fd();
                if (f < n - 1) begin
                    chk(run, 1, "R4 sweep running");
                    chk(frame_idx, f + 1, "R4 sweep idx");
                end else begin
                    chk(run, 0, "R4 sweep end run");
                    chk(frame_idx, 0, "R4 sweep end idx");
                end
            end
            expv = 4'b0011 | ((pk < n) ? 4'b0100 : 4'b0000);
            for (int k = 0; k < 4; k++) begin
                setmask(~(1 << k) & 4'hF);
                case (k)
                    0: chk(irq, (expv >> k) & 1, "R6 frame end status");
                    1: chk(irq, (expv >> k) & 1, "R7 update end status");
                    2: chk(irq, (expv >> k) & 1, "R8 chosen frame status");
                    default: chk(irq, (expv >> k) & 1, "R9 no line flag");
                endcase
            end
        end

        // line flag across two frames
        cur_pick = 0;
        wr(2'd2, 20'd2);
        irqw(4'h7, 4'hF, 0);
        commit();
        launch(2);
        lp(); lp();
        chk(irq, 0, "R9 before line match");
        lp();
        chk(irq, 1, "R9 line match frame0");
        irqw(4'h7, 4'h8, 0);
        chk(irq, 0, "R11 line clear");
        fd();
        chk(frame_idx, 1, "R4 second frame");
        lp(); lp();
        chk(irq, 0, "R9 count restarts");
        lp();
        chk(irq, 1, "R9 line match frame1");
        fd();
        chk(run, 0, "R4 two-frame end");

        // exhaustive mask sweep against shrinking status
        remain = 4'hF;
        for (int m = 0; m < 16; m++) begin
            setmask(m);
            chk(irq, (m != 15) ? 1 : 0, "R10 full status mask");
        end
        for (int c = 0; c < 4; c++) begin
            irqw(4'hF, 1 << c, 0);
            remain = remain & ~(1 << c);
            for (int m = 0; m < 16; m++) begin
                setmask(m);
                chk(irq, ((remain & ~m & 4'hF) != 0) ? 1 : 0, "R10 partial status mask");
            end
        end

        // idle pulses have no effect
        setmask(4'h7);
        lp(); lp(); lp(); lp();
        chk(irq, 0, "R9 idle line ignored");
        setmask(4'hE);
        fd();
        chk(irq, 0, "R6 idle frame ignored");
        chk(frame_idx, 0, "R4 idle frame idx");

        // relaunch while running
        irqw(4'hF, 4'hF, 0);
        commit();
        launch(4);
        fd();
        chk(frame_idx, 1, "R4 relaunch base");
        wr(2'd0, 20'(3 << 2));
        commit();
        chk(run, 1, "R5 start low while running");
        chk(frame_idx, 1, "R5 idx after start low");
        wr(2'd0, 20'd1);
        commit();
        chk(run, 1, "R5 relaunch ignored run");
        chk(frame_idx, 1, "R5 relaunch ignored idx");
        fd(); fd();
        chk(run, 1, "R5 original count kept");
        chk(frame_idx, 3, "R5 idx kept counting");
        fd();
        chk(run, 0, "R5 ends at original count");

        // set beats clear in the same cycle
        setmask(4'hE);
        irqw(4'hE, 4'hF, 0);
        launch(2);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 20'((1 << 8) | (4'hE << 4));
        frame_done = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; frame_done = 1'b0;
        chk(irq, 1, "R11 set wins over clear");
        irqw(4'hE, 1, 0);
        chk(irq, 0, "R11 later clear");
        fd();
        chk(run, 0, "R4 final end");

        summary();
        $finish;
    end

endmodule